// File: doc/BRIEF.md
# Converter Soft-Start Sequencer

This block brings a multiphase switching regulator from rest to regulated operation. A four-state machine steps from rest through a fixed dead-time interval and a ramped soft-start interval into steady run. A bypass request can take it straight from rest to run. The request comes from either an external pin or a configuration bit.

Two asynchronous requests come from the analog loop: a switching-event request and an end-of-soft-start request. Each passes through a two-flop synchronizer.

During soft-start, the high-side pulse request does not follow the analog switching request. It is taken from the carry-out of a phase accumulator whose increment grows on every carry, so pulse density rises over time. In run, every rising edge of the synchronized switching request produces one single-cycle pulse.

Top module: `softstart_seq`

## Requirements
- R1: The state output encodes rest=0, dead-time=1, soft-start=2 and run=3. Without bypass, the only forward path is 0→1→2→3. Any state returns to 0 on the clock edge after the enable is seen low.
- R2: In state 0 with the enable high, the next state is 3 when the bypass pin or the bypass configuration bit is high. The bypass inputs are ignored in every other state.
- R3: The comparator-force flag is high exactly in state 1. The soft-start-busy flag is high exactly in state 2. The soft-start-done flag is high exactly in state 3.
- R4: A high level on the end-of-soft-start request while in state 2 makes the state 3 on the third clock edge after the request is applied.
- R5: In state 2, the high-side pulse equals the accumulator tick. Switching-request activity has no effect on it.
- R6: While the enable input is low, every flag, pulse and tick output is 0 in the same cycle.
- R7: The forced-CCM output is high only in state 3, and only while the forced-CCM configuration bit is 1.
- R8: In state 3, a rising edge on the switching request gives a high-side pulse exactly one cycle wide, starting two clock edges after the edge is applied.
- R9: The dead-time state lasts exactly DEAD_CYC clock cycles (default 32).
- R10: The accumulator is ACC_W bits (default 16). It starts at 0 with the increment at the start value on entry to state 2. Each cycle it adds the increment, and a carry-out is a tick. On each tick the increment grows by the step value and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable |
| bypass_pin_i | input | 1 | External soft-start bypass request |
| bypass_cfg_i | input | 1 | Configuration bypass bit |
| ccm_cfg_i | input | 1 | Forced-CCM configuration bit |
| inc_start_i | input | ACC_W | Initial accumulator increment |
| inc_step_i | input | ACC_W | Increment growth per tick |
| sw_evt_a_i | input | 1 | Asynchronous switching-event request |
| ss_end_a_i | input | 1 | Asynchronous end-of-soft-start request |
| state_o | output | 2 | Current state code |
| comp_force_o | output | 1 | Comparator-force flag |
| ss_busy_o | output | 1 | Soft-start active flag |
| ss_fin_o | output | 1 | Soft-start done flag |
| fccm_o | output | 1 | Forced-CCM request |
| hs_pulse_o | output | 1 | High-side pulse request |
| tick_o | output | 1 | Accumulator carry tick |

## Verification
The state code and the three exclusive flags show a wrong state at once, in the same cycle the state register holds it. A faulty dead-time counter shows as a wrong count of comparator-force cycles. A corrupted accumulator or increment shows within one tick period, because every soft-start cycle's pulse is compared with an arithmetic model across a sweep of start and step values. A broken synchronizer or edge detector shifts the pulse or the run entry away from its expected clock edge.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEAD = 2'd1,
        ST_SOFT = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    output logic s_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], a_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign s_o = sh_q[STAGES-1];
endmodule

// File: rtl/seq_dds.sv
module seq_dds #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [ACC_W-1:0] inc_start_i,
    input  logic [ACC_W-1:0] inc_step_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] inc;
    } dds_t;

    dds_t           r_d, r_q;
    logic [ACC_W:0] sum, inc_sum;

    always_comb begin
        sum     = {1'b0, r_q.acc} + {1'b0, r_q.inc};
        inc_sum = {1'b0, r_q.inc} + {1'b0, inc_step_i};
        tick_o  = run_i & sum[ACC_W];
        r_d     = r_q;
        if (!run_i) begin
            r_d.acc = '0;
            r_d.inc = inc_start_i;
        end else begin
            r_d.acc = sum[ACC_W-1:0];
            if (sum[ACC_W]) begin
                r_d.inc = inc_sum[ACC_W] ? {ACC_W{1'b1}} : inc_sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm import seq_pkg::*; #(
    parameter int DEAD_CYC = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       bypass_i,
    input  logic       ss_end_i,
    output seq_state_e state_o
);
    localparam int CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!enable_i) begin
            f_d.st  = ST_IDLE;
            f_d.cnt = '0;
        end else begin
            unique case (f_q.st)
                ST_IDLE: begin
                    f_d.cnt = '0;
                    f_d.st  = bypass_i ? ST_RUN : ST_DEAD;
                end
                ST_DEAD: begin
                    if (f_q.cnt == DEAD_LAST) begin
                        f_d.st  = ST_SOFT;
                        f_d.cnt = '0;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_SOFT: if (ss_end_i) f_d.st = ST_RUN;
                ST_RUN:  f_d.st = ST_RUN;
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, cnt: '0};
        else        f_q <= f_d;
    end

    assign state_o = f_q.st;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq import seq_pkg::*; #(
    parameter int ACC_W       = 16,
    parameter int DEAD_CYC    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             bypass_pin_i,
    input  logic             bypass_cfg_i,
    input  logic             ccm_cfg_i,
    input  logic [ACC_W-1:0] inc_start_i,
    input  logic [ACC_W-1:0] inc_step_i,
    input  logic             sw_evt_a_i,
    input  logic             ss_end_a_i,
    output logic [1:0]       state_o,
    output logic             comp_force_o,
    output logic             ss_busy_o,
    output logic             ss_fin_o,
    output logic             fccm_o,
    output logic             hs_pulse_o,
    output logic             tick_o
);
    localparam int N_ASYNC = 2;
    localparam int IDX_SW  = 0;
    localparam int IDX_END = 1;

    logic [N_ASYNC-1:0] raw, synced;
    assign raw = {ss_end_a_i, sw_evt_a_i};

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .a_i  (raw[g]),
            .s_o  (synced[g])
        );
    end

    seq_state_e st;
    logic       dds_tick;

    seq_fsm #(.DEAD_CYC(DEAD_CYC)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable_i(enable_i),
        .bypass_i(bypass_pin_i | bypass_cfg_i),
        .ss_end_i(synced[IDX_END]),
        .state_o (st)
    );

    seq_dds #(.ACC_W(ACC_W)) dds_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (st == ST_SOFT),
        .inc_start_i(inc_start_i),
        .inc_step_i (inc_step_i),
        .tick_o     (dds_tick)
    );

    logic sw_prev_d, sw_prev_q, sw_rise;

    always_comb begin
        sw_prev_d = synced[IDX_SW];
        sw_rise   = synced[IDX_SW] & ~sw_prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_prev_q <= 1'b0;
        else        sw_prev_q <= sw_prev_d;
    end

    always_comb begin
        state_o      = st;
        comp_force_o = enable_i & (st == ST_DEAD);
        ss_busy_o    = enable_i & (st == ST_SOFT);
        ss_fin_o     = enable_i & (st == ST_RUN);
        fccm_o       = ss_fin_o & ccm_cfg_i;
        tick_o       = enable_i & dds_tick;
        hs_pulse_o   = (ss_busy_o & dds_tick) | (ss_fin_o & sw_rise);
    end
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       bypass_pin_i,
    input logic       bypass_cfg_i,
    input logic       ccm_cfg_i,
    input logic [1:0] state_o,
    input logic       comp_force_o,
    input logic       ss_busy_o,
    input logic       ss_fin_o,
    input logic       fccm_o,
    input logic       hs_pulse_o,
    input logic       tick_o
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({comp_force_o, ss_busy_o, ss_fin_o})); // R3
    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i |-> (comp_force_o == (state_o == 2'd1)) && (ss_busy_o == (state_o == 2'd2))
                     && (ss_fin_o == (state_o == 2'd3))); // R3
    AST_BYPASS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && enable_i && (bypass_pin_i || bypass_cfg_i)) |=> state_o == 2'd3); // R2
    AST_FWD_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |=> state_o != 2'd3); // R1
    AST_FWD_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |=> state_o != 2'd1); // R1
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> state_o == 2'd0); // R1
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !(comp_force_o || ss_busy_o || ss_fin_o || fccm_o || hs_pulse_o || tick_o)); // R6
    AST_FCCM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fccm_o |-> (ss_fin_o && ccm_cfg_i)); // R7
    AST_SOFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_busy_o |-> (hs_pulse_o == tick_o)); // R5
    AST_TICK_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> ss_busy_o); // R10
    AST_RUN_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_pulse_o && ss_fin_o) |=> !hs_pulse_o); // R8
endmodule

bind softstart_seq softstart_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .bypass_pin_i(bypass_pin_i),
    .bypass_cfg_i(bypass_cfg_i), .ccm_cfg_i(ccm_cfg_i), .state_o(state_o),
    .comp_force_o(comp_force_o), .ss_busy_o(ss_busy_o), .ss_fin_o(ss_fin_o),
    .fccm_o(fccm_o), .hs_pulse_o(hs_pulse_o), .tick_o(tick_o)
);

// File: tb/softstart_seq_tb_top.sv
`timescale 1ns/1ps
module softstart_seq_tb_top;
    localparam int ACC_W    = 16;
    localparam int DEAD_CYC = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0, bypass_pin_i = 1'b0, bypass_cfg_i = 1'b0, ccm_cfg_i = 1'b0;
    logic [ACC_W-1:0] inc_start_i = '0, inc_step_i = '0;
    logic sw_evt_a_i = 1'b0, ss_end_a_i = 1'b0;
    logic [1:0] state_o;
    logic comp_force_o, ss_busy_o, ss_fin_o, fccm_o, hs_pulse_o, tick_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    softstart_seq #(.ACC_W(ACC_W), .DEAD_CYC(DEAD_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .bypass_pin_i(bypass_pin_i),
        .bypass_cfg_i(bypass_cfg_i), .ccm_cfg_i(ccm_cfg_i), .inc_start_i(inc_start_i),
        .inc_step_i(inc_step_i), .sw_evt_a_i(sw_evt_a_i), .ss_end_a_i(ss_end_a_i),
        .state_o(state_o), .comp_force_o(comp_force_o), .ss_busy_o(ss_busy_o),
        .ss_fin_o(ss_fin_o), .fccm_o(fccm_o), .hs_pulse_o(hs_pulse_o), .tick_o(tick_o)
    );

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int outs_bits();
        return {26'd0, comp_force_o, ss_busy_o, ss_fin_o, fccm_o, hs_pulse_o, tick_o};
    endfunction

    // back to rest, then enable without bypass; returns number of dead-time cycles seen
    task automatic start_up(output int dead_n);
        enable_i = 1'b0; bypass_pin_i = 1'b0; bypass_cfg_i = 1'b0;
        step(2);
        enable_i = 1'b1;
        step();
        dead_n = 0;
        while (state_o == 2'd1 && dead_n < 1000) begin
            dead_n++;
            step();
        end
    endtask

    // soft-start sweep against the arithmetic model (R5, R10)
    task automatic soft_sweep(input int start, input int stp, input int cycles);
        longint m_acc, m_inc, m_sum, lim;
        int dn, ticks;
        inc_start_i = ACC_W'(start);
        inc_step_i  = ACC_W'(stp);
        start_up(dn);
        chk("R1 soft-start after dead-time", state_o, 2);
        lim   = (64'd1 << ACC_W);
        m_acc = 0;
        m_inc = start;
        ticks = 0;
        for (int i = 0; i < cycles; i++) begin
            sw_evt_a_i = ((i % 3) == 0);
            m_sum = m_acc + m_inc;
            chk("R10 tick", tick_o, (m_sum >= lim) ? 1 : 0);
            chk("R5 pulse equals tick", hs_pulse_o, (m_sum >= lim) ? 1 : 0);
            if (m_sum >= lim) begin
                ticks++;
                m_inc = m_inc + stp;
                if (m_inc >= lim) m_inc = lim - 1;
            end
            m_acc = m_sum % lim;
            step();
        end
        sw_evt_a_i = 1'b0;
        if (start == 0) chk("R5 no pulses with zero increment", ticks, 0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int dn, pulses;
        step(3);
        chk("R1 reset state", state_o, 0);
        chk("R6 reset outputs", outs_bits(), 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 idle while disabled", state_o, 0);

        // main startup with forced CCM set
        ccm_cfg_i = 1'b1;
        inc_start_i = 16'h1000; inc_step_i = 16'h0800;
        enable_i = 1'b1;
        step();
        chk("R1 dead-time entered", state_o, 1);
        chk("R3 comp force in dead-time", comp_force_o, 1);
        chk("R7 no fccm in dead-time", fccm_o, 0);
        dn = 1;
        step();
        while (state_o == 2'd1 && dn < 1000) begin dn++; step(); end
        chk("R9 dead-time length", dn, DEAD_CYC);
        chk("R3 busy in soft-start", ss_busy_o, 1);
        chk("R3 no comp force in soft-start", comp_force_o, 0);
        chk("R7 no fccm in soft-start", fccm_o, 0);

        ss_end_a_i = 1'b1;
        step(2);
        chk("R4 still soft-start after two edges", state_o, 2);
        step();
        chk("R4 run on third edge", state_o, 3);
        chk("R3 done flag in run", ss_fin_o, 1);
        chk("R7 fccm in run with bit set", fccm_o, 1);
        ss_end_a_i = 1'b0;
        ccm_cfg_i = 1'b0;
        #0.5;
        chk("R7 fccm follows config bit", fccm_o, 0);
        step(3);

        // run-state pulses
        sw_evt_a_i = 1'b1;
        step();
        chk("R8 no pulse after one edge", hs_pulse_o, 0);
        step();
        chk("R8 pulse after two edges", hs_pulse_o, 1);
        step();
        chk("R8 pulse one cycle wide", hs_pulse_o, 0);
        step(4);
        chk("R8 held level no pulse", hs_pulse_o, 0);
        sw_evt_a_i = 1'b0;
        step(4);
        pulses = 0;
        for (int k = 0; k < 80; k++) begin
            sw_evt_a_i = ((k % 8) < 3);
            if (hs_pulse_o) pulses++;
            step();
        end
        sw_evt_a_i = 1'b0;
        step(4);
        if (hs_pulse_o) pulses++;
        chk("R8 one pulse per rising edge", pulses, 10);

        // disable
        enable_i = 1'b0;
        #0.5;
        chk("R6 outputs quiet when disabled", outs_bits(), 0);
        step();
        chk("R1 back to idle", state_o, 0);

        // bypass paths
        bypass_cfg_i = 1'b1;
        enable_i = 1'b1;
        step();
        chk("R2 config bypass to run", state_o, 3);
        chk("R7 fccm low with bit clear", fccm_o, 0);
        enable_i = 1'b0; bypass_cfg_i = 1'b0;
        step();
        bypass_pin_i = 1'b1; ccm_cfg_i = 1'b1;
        enable_i = 1'b1;
        step();
        chk("R2 pin bypass to run", state_o, 3);
        chk("R7 fccm in run", fccm_o, 1);
        enable_i = 1'b0; bypass_pin_i = 1'b0;
        step();
        enable_i = 1'b1;
        step();
        chk("R2 dead-time without bypass", state_o, 1);
        bypass_pin_i = 1'b1; bypass_cfg_i = 1'b1;
        step();
        chk("R2 bypass ignored in dead-time", state_o, 1);
        bypass_pin_i = 1'b0; bypass_cfg_i = 1'b0;

        // accumulator sweep
        foreach (inc_start_i[b]) begin end
        for (int si = 0; si < 5; si++) begin
            for (int ti = 0; ti < 3; ti++) begin
                int sv, tv;
                sv = (si == 0) ? 0 : (si == 1) ? 16'h0400 : (si == 2) ? 16'h1000 :
                     (si == 3) ? 16'h3000 : 16'hF000;
                tv = (ti == 0) ? 0 : (ti == 1) ? 16'h0100 : 16'h4000;
                soft_sweep(sv, tv, 150);
                if (ti == 2) begin
                    start_up(dn);
                    chk("R9 dead-time length in sweep", dn, DEAD_CYC);
                end
            end
        end

        enable_i = 1'b0;
        step(2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule